// File: doc/BRIEF.md
# Dual-Rule Cellular Automaton Generation Engine

This block advances a two-dimensional grid of cells by one generation each time it gets a frame tick. Every cell is held as a 2-bit state in a double-buffered on-chip array. The engine reads only the current buffer and writes only the next one. When every cell has been written, the buffers swap roles and a one-cycle completion pulse is raised. A single select input picks between two rule sets. One is a wire-and-electron rule, with states empty, conductor, electron head and electron tail. The other is the classic birth/survival life rule. The select is captured when a generation starts, so flipping it never corrupts a generation that is already in progress.

Eight update iterators share one memory array through a round-robin arbiter that grants one access per cycle. Rows are dealt out to the iterators in interleaved order: iterator i handles rows i, i+8, i+16 and so on. Each iterator walks its row left to right and keeps a 3x3 window of registers. For each new column it fetches only the three cells of that column, so no cell is read twice while that row is processed. Cells beyond the grid edge read as empty.

A host loads cells through a valid/ready load port. The port is ready only while the engine is idle, and while it is busy a load simply waits with `ld_valid` held. The display side reads the current generation through a combinational peek port. Colour is derived from the returned state and is not stored.

Top module: `ca_gen_engine`

## Requirements
- R1: Cell code 0 is empty, 1 is conductor, 2 is electron head and 3 is electron tail. A load accepted while `ld_valid` and `ld_ready` are both high writes `ld_state` into the current generation at index row*COLS+col. `pk_state` returns the current-generation state at `pk_addr` in the same cycle.
- R2: In wire mode (`rule_life`=0), a head becomes a tail, a tail becomes a conductor, and an empty cell stays empty.
- R3: In wire mode, a conductor becomes a head when exactly one or two of its eight neighbours are heads. Otherwise it stays a conductor.
- R4: In life mode (`rule_life`=1), any nonzero code counts as alive. A live cell with 2 or 3 live neighbours survives, and an empty cell with exactly 3 becomes live. Every live result is written as code 1 and every dead result as code 0.
- R5: Neighbours that fall outside the grid count as empty in both modes.
- R6: Every next-generation cell is computed only from the previous generation, never from cells already updated in the same generation.
- R7: `rule_life` is sampled when a generation starts. Changing it while `busy` is high has no effect on that generation.
- R8: A `tick` while idle starts exactly one generation and raises `busy`. A `tick` while busy is ignored.
- R9: `gen_done` is a single-cycle pulse, raised together with the fall of `busy` once all cells have been written. From that cycle on, `pk_state` shows the new generation.
- R10: `ld_ready` is low whenever `busy` is high.
- R11: The memory arbiter grants at most one iterator per cycle. It never grants the same iterator twice in a row while another iterator is requesting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Frame tick; starts a generation when idle |
| rule_life | input | 1 | 0 selects wire rules, 1 selects life rules |
| busy | output | 1 | A generation is being computed |
| gen_done | output | 1 | One-cycle pulse when a generation completes |
| ld_valid | input | 1 | Load request valid |
| ld_ready | output | 1 | Load accepted this cycle when high with `ld_valid` |
| ld_addr | input | AW | Cell index row*COLS+col for the load |
| ld_state | input | 2 | Cell code to load |
| pk_addr | input | AW | Cell index to peek |
| pk_state | output | 2 | Current-generation state at `pk_addr` |

## Verification
Each bench generation is compared in full against an arithmetic model. The grids use random mixes of all four codes in both modes, plus conductor loops and heads placed right on the grid border. A design that lets an updated cell leak into a neighbour's evaluation, or that wraps or reads garbage past an edge, would diverge after one step. The bench flips `rule_life` and pulses `tick` a second time while a generation is running. A design that sampled the select late, or that chained a second generation, would land on a different grid or raise a second `gen_done`. Live cells loaded as heads and tails check that life mode rewrites survivors as code 1. The bench also checks that the load port refuses data while busy and that the completion pulse lasts one cycle.

// File: rtl/ca_pkg.sv
package ca_pkg;
  typedef enum logic [1:0] {
    CELL_EMPTY = 2'd0,
    CELL_WIRE  = 2'd1,
    CELL_HEAD  = 2'd2,
    CELL_TAIL  = 2'd3
  } cell_t;
endpackage

// File: rtl/ca_rule.sv
// Next-state evaluation for one 3x3 neighbourhood; centre is slot 4.
module ca_rule
  import ca_pkg::*;
(
  input  logic        life,
  input  logic [17:0] nbhd,
  output logic [1:0]  next
);
  logic [1:0] ctr;
  logic [3:0] heads;
  logic [3:0] alive;

  always_comb begin
    ctr   = nbhd[9:8];
    heads = '0;
    alive = '0;
    for (int s = 0; s < 9; s++) begin
      if (s != 4) begin
        if (nbhd[s*2 +: 2] == CELL_HEAD) heads = heads + 4'd1;
        if (nbhd[s*2 +: 2] != CELL_EMPTY) alive = alive + 4'd1;
      end
    end
    next = CELL_EMPTY;
    if (life) begin
      if (ctr != CELL_EMPTY) next = (alive == 4'd2 || alive == 4'd3) ? CELL_WIRE : CELL_EMPTY;
      else                   next = (alive == 4'd3) ? CELL_WIRE : CELL_EMPTY;
    end else begin
      case (ctr)
        CELL_HEAD: next = CELL_TAIL;
        CELL_TAIL: next = CELL_WIRE;
        CELL_WIRE: next = (heads == 4'd1 || heads == 4'd2) ? CELL_HEAD : CELL_WIRE;
        default:   next = CELL_EMPTY;
      endcase
    end
  end
endmodule

// File: rtl/ca_rr_arb.sv
// Round-robin grant of one requester per cycle.
module ca_rr_arb #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  localparam int PW = (N > 1) ? $clog2(N) : 1;
  logic [PW-1:0] ptr;
  logic [PW-1:0] win;
  logic          any;

  always_comb begin
    gnt = '0;
    win = ptr;
    any = 1'b0;
    for (int off = 0; off < N; off++) begin
      int idx;
      idx = (int'(ptr) + off) % N;
      if (!any && req[idx]) begin
        any      = 1'b1;
        win      = PW'(idx);
        gnt[idx] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   ptr <= '0;
    else if (any) ptr <= (int'(win) == N - 1) ? '0 : win + PW'(1);
  end

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt)); // R11
  AST_RR_ROTATE: assert property (@(posedge clk) disable iff (!rst_n)
    ((gnt != '0) && ((req & ~gnt) != '0)) |=> (gnt != $past(gnt))); // R11
endmodule

// File: rtl/ca_iter.sv
// One update iterator: walks its interleaved rows with a 3x3 window.
module ca_iter
  import ca_pkg::*;
#(
  parameter int COLS  = 12,
  parameter int ROWS  = 10,
  parameter int NITER = 8,
  parameter int ID    = 0,
  parameter int AW    = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          life,
  input  logic          gnt,
  input  logic [1:0]    rdata,
  output logic          req,
  output logic          we,
  output logic [AW-1:0] addr,
  output logic [1:0]    wdata,
  output logic          done
);
  localparam int CW = $clog2(COLS + 1);
  localparam int RW = $clog2(ROWS + NITER + 1);

  typedef enum logic [1:0] {IT_IDLE, IT_RD, IT_WR, IT_DONE} it_st_t;
  it_st_t        st;
  logic [RW-1:0] row;
  logic [CW-1:0] col;
  logic [1:0]    k;
  logic [1:0]    w  [3][3];
  logic [1:0]    nc [2];
  logic          oob;
  logic          proceed;
  logic [1:0]    rval;
  logic [17:0]   nbhd;
  logic [1:0]    nxt;
  int            rr;

  always_comb begin
    rr   = int'(row) + int'(k) - 1;
    oob  = (rr < 0) || (rr >= ROWS) || (int'(col) == COLS);
    rval = oob ? CELL_EMPTY : rdata;
    proceed = oob || gnt;
    for (int r = 0; r < 3; r++)
      for (int c = 0; c < 3; c++)
        nbhd[(r*3+c)*2 +: 2] = w[r][c];
    req   = ((st == IT_RD) && !oob) || (st == IT_WR);
    we    = (st == IT_WR);
    wdata = nxt;
    if (st == IT_WR) addr = AW'(int'(row) * COLS + int'(col) - 1);
    else             addr = AW'((rr < 0 ? 0 : rr) * COLS + int'(col));
    done  = (st == IT_DONE);
  end

  ca_rule u_rule (.life(life), .nbhd(nbhd), .next(nxt));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= IT_IDLE;
      row <= '0;
      col <= '0;
      k   <= '0;
      for (int r = 0; r < 3; r++) for (int c = 0; c < 3; c++) w[r][c] <= CELL_EMPTY;
      nc[0] <= CELL_EMPTY;
      nc[1] <= CELL_EMPTY;
    end else begin
      case (st)
        IT_IDLE, IT_DONE: if (start) begin
          row <= RW'(ID);
          col <= '0;
          k   <= '0;
          for (int r = 0; r < 3; r++) for (int c = 0; c < 3; c++) w[r][c] <= CELL_EMPTY;
          st  <= (ID < ROWS) ? IT_RD : IT_DONE;
        end
        IT_RD: if (proceed) begin
          if (k < 2'd2) begin
            nc[k[0]] <= rval;
            k        <= k + 2'd1;
          end else begin
            k <= '0;
            for (int r = 0; r < 3; r++) begin
              w[r][0] <= w[r][1];
              w[r][1] <= w[r][2];
            end
            w[0][2] <= nc[0];
            w[1][2] <= nc[1];
            w[2][2] <= rval;
            if (col == '0) col <= CW'(1);
            else           st  <= IT_WR;
          end
        end
        IT_WR: if (gnt) begin
          if (int'(col) == COLS) begin
            col <= '0;
            for (int r = 0; r < 3; r++) for (int c = 0; c < 3; c++) w[r][c] <= CELL_EMPTY;
            if (int'(row) + NITER < ROWS) begin
              row <= row + RW'(NITER);
              st  <= IT_RD;
            end else begin
              st  <= IT_DONE;
            end
          end else begin
            col <= col + CW'(1);
            st  <= IT_RD;
          end
        end
        default: st <= IT_IDLE;
      endcase
    end
  end

  AST_LIFE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (we && life) |-> (wdata == CELL_EMPTY || wdata == CELL_WIRE)); // R4
  AST_COL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(col) <= COLS); // R5
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !gnt) |=> (we && $stable(addr))); // R11
endmodule

// File: rtl/ca_gen_engine.sv
// Top: double-buffered cell store, eight iterators, generation control.
module ca_gen_engine
  import ca_pkg::*;
#(
  parameter int COLS  = 12,
  parameter int ROWS  = 10,
  parameter int NITER = 8,
  localparam int CELLS = COLS * ROWS,
  localparam int AW    = $clog2(CELLS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          rule_life,
  output logic          busy,
  output logic          gen_done,
  input  logic          ld_valid,
  output logic          ld_ready,
  input  logic [AW-1:0] ld_addr,
  input  logic [1:0]    ld_state,
  input  logic [AW-1:0] pk_addr,
  output logic [1:0]    pk_state
);
  logic [1:0]       mem [2][CELLS];
  logic             cur;
  logic             rule_q;
  logic             start;
  logic [NITER-1:0] req, we_v, done_v, gnt;
  logic [AW-1:0]    addr_v  [NITER];
  logic [1:0]       wdata_v [NITER];
  logic [AW-1:0]    g_addr;
  logic [1:0]       g_wdata;
  logic             g_we;
  logic [1:0]       rdata;
  logic             all_done;

  assign start    = tick && !busy;
  assign ld_ready = !busy;
  assign all_done = &done_v;
  assign pk_state = mem[cur][pk_addr];
  assign rdata    = mem[cur][g_addr];

  ca_rr_arb #(.N(NITER)) u_arb (.clk(clk), .rst_n(rst_n), .req(req), .gnt(gnt));

  for (genvar i = 0; i < NITER; i++) begin : g_it
    ca_iter #(.COLS(COLS), .ROWS(ROWS), .NITER(NITER), .ID(i), .AW(AW)) u_it (
      .clk(clk), .rst_n(rst_n), .start(start), .life(rule_q),
      .gnt(gnt[i]), .rdata(rdata), .req(req[i]), .we(we_v[i]),
      .addr(addr_v[i]), .wdata(wdata_v[i]), .done(done_v[i]));
  end

  always_comb begin
    g_addr  = '0;
    g_wdata = CELL_EMPTY;
    g_we    = 1'b0;
    for (int i = 0; i < NITER; i++) begin
      if (gnt[i]) begin
        g_addr  = addr_v[i];
        g_wdata = wdata_v[i];
        g_we    = we_v[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (ld_valid && ld_ready) mem[cur][ld_addr] <= ld_state;
    if (g_we)                 mem[!cur][g_addr] <= g_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur      <= 1'b0;
      busy     <= 1'b0;
      gen_done <= 1'b0;
      rule_q   <= 1'b0;
    end else begin
      gen_done <= 1'b0;
      if (start) begin
        busy   <= 1'b1;
        rule_q <= rule_life;
      end else if (busy && all_done) begin
        busy     <= 1'b0;
        gen_done <= 1'b1;
        cur      <= !cur;
      end
    end
  end

  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !all_done) |=> busy); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    gen_done |=> !gen_done); // R9
  AST_DONE_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    gen_done |-> (cur != $past(cur))); // R6
  AST_RULE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(rule_q)); // R7
  AST_NO_LOAD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ld_ready); // R10
endmodule

// File: tb/tb_ca_gen_engine.sv
module tb_ca_gen_engine;
  localparam int COLS  = 12;
  localparam int ROWS  = 10;
  localparam int NITER = 8;
  localparam int CELLS = COLS * ROWS;
  localparam int AW    = $clog2(CELLS);

  logic clk = 1'b0;
  logic rst_n, tick, rule_life, busy, gen_done, ld_valid, ld_ready;
  logic [AW-1:0] ld_addr, pk_addr;
  logic [1:0]    ld_state, pk_state;

  int errors = 0;
  int checks = 0;
  int g  [CELLS];
  int gn [CELLS];

  always #5 clk = ~clk;

  ca_gen_engine #(.COLS(COLS), .ROWS(ROWS), .NITER(NITER)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rule_life(rule_life),
    .busy(busy), .gen_done(gen_done), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_addr(ld_addr), .ld_state(ld_state), .pk_addr(pk_addr), .pk_state(pk_state));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int cell_at(int r, int c);
    if (r < 0 || r >= ROWS || c < 0 || c >= COLS) return 0; // R5
    return g[r*COLS + c];
  endfunction

  task automatic model_step(input bit life);
    for (int r = 0; r < ROWS; r++) begin
      for (int c = 0; c < COLS; c++) begin
        int h, a, s;
        h = 0; a = 0; s = g[r*COLS+c];
        for (int dr = -1; dr <= 1; dr++)
          for (int dc = -1; dc <= 1; dc++)
            if (dr != 0 || dc != 0) begin
              if (cell_at(r+dr, c+dc) == 2) h++;
              if (cell_at(r+dr, c+dc) != 0) a++;
            end
        if (life) gn[r*COLS+c] = (s != 0) ? ((a == 2 || a == 3) ? 1 : 0) : ((a == 3) ? 1 : 0);
        else if (s == 2) gn[r*COLS+c] = 3;
        else if (s == 3) gn[r*COLS+c] = 1;
        else if (s == 1) gn[r*COLS+c] = (h == 1 || h == 2) ? 2 : 1;
        else gn[r*COLS+c] = 0;
      end
    end
    for (int i = 0; i < CELLS; i++) g[i] = gn[i];
  endtask

  task automatic load_grid();
    for (int i = 0; i < CELLS; i++) begin
      @(negedge clk);
      ld_valid = 1'b1; ld_addr = AW'(i); ld_state = 2'(g[i]);
    end
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic compare_grid(input string req);
    int bad, first, act;
    bad = 0; first = -1; act = 0;
    for (int i = 0; i < CELLS; i++) begin
      pk_addr = AW'(i);
      #1;
      if (int'(pk_state) != g[i]) begin
        if (first < 0) begin first = i; act = int'(pk_state); end
        bad++;
      end
    end
    check(bad == 0, req, act, (first < 0) ? 0 : g[first]);
    if (first >= 0) $display("  first mismatch at cell %0d, %0d bad", first, bad);
  endtask

  task automatic run_gen(input bit life, input string req);
    int n;
    @(negedge clk);
    rule_life = life; tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    n = 0;
    while (!gen_done && n < 20000) begin @(negedge clk); n++; end
    check(gen_done == 1'b1, "R9 gen_done seen", int'(gen_done), 1);
    check(busy == 1'b0, "R9 busy low at done", int'(busy), 0);
    model_step(life);
    compare_grid(req);
    @(negedge clk);
    check(gen_done == 1'b0, "R9 single-cycle pulse", int'(gen_done), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tick = 1'b0; rule_life = 1'b0; ld_valid = 1'b0;
    ld_addr = '0; ld_state = '0; pk_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 1'b0, "R8 reset idle", int'(busy), 0);
    check(gen_done == 1'b0, "R9 reset no pulse", int'(gen_done), 0);
    check(ld_ready == 1'b1, "R10 ready when idle", int'(ld_ready), 1);

    // R1: load/peek round trip of all four codes
    for (int i = 0; i < CELLS; i++) g[i] = i % 4;
    load_grid();
    compare_grid("R1 load and peek");

    // R2 R3 R6: random wire grids, several generations
    for (int i = 0; i < CELLS; i++) begin
      int v;
      v = $urandom_range(0, 9);
      g[i] = (v < 3) ? 0 : (v < 7) ? 1 : (v < 8) ? 2 : 3;
    end
    load_grid();
    for (int s = 0; s < 5; s++) run_gen(1'b0, "R2 R3 R6 wire step");

    // R5: wire ring on the border with heads in the corners
    for (int i = 0; i < CELLS; i++) g[i] = 0;
    for (int c = 0; c < COLS; c++) begin g[c] = 1; g[(ROWS-1)*COLS+c] = 1; end
    for (int r = 0; r < ROWS; r++) begin g[r*COLS] = 1; g[r*COLS+COLS-1] = 1; end
    g[0] = 2; g[CELLS-1] = 2; g[COLS-1] = 3;
    load_grid();
    for (int s = 0; s < 4; s++) run_gen(1'b0, "R5 border wire step");

    // R4: random life grid with all nonzero codes counting as alive
    for (int i = 0; i < CELLS; i++) g[i] = ($urandom_range(0, 2) == 0) ? int'($urandom_range(1, 3)) : 0;
    load_grid();
    for (int s = 0; s < 5; s++) run_gen(1'b1, "R4 R5 life step");

    // R4: blinker written with head/tail codes at the corner
    for (int i = 0; i < CELLS; i++) g[i] = 0;
    g[0] = 2; g[1] = 3; g[2] = 2;
    load_grid();
    run_gen(1'b1, "R4 corner blinker");

    // R7 R8 R10: select flip and extra tick during a busy generation
    for (int i = 0; i < CELLS; i++) g[i] = int'($urandom_range(0, 3));
    load_grid();
    @(negedge clk);
    rule_life = 1'b0; tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    check(busy == 1'b1, "R8 tick starts", int'(busy), 1);
    check(ld_ready == 1'b0, "R10 not ready while busy", int'(ld_ready), 0);
    repeat (4) @(negedge clk);
    rule_life = 1'b1; tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    begin
      int n, pulses;
      n = 0; pulses = 0;
      while (n < 3000) begin
        if (gen_done) pulses++;
        @(negedge clk); n++;
      end
      check(pulses == 1, "R8 one generation per idle tick", pulses, 1);
    end
    model_step(1'b0);
    compare_grid("R7 select latched at start");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule